// File: doc/BRIEF.md
# Ping-Pong Dual-Bank Packet Buffer

This block holds packet data for a link controller in two ping-pong pairs of byte-wide synchronous RAM. The transmit pair takes bytes from the host and gives them to the link-side DMA. The receive pair takes bytes from the DMA and gives them to the host. In each pair one physical bank belongs to the host and the other belongs to the DMA. The host can therefore fill or drain a whole packet while the DMA streams the previous one, and the two sides never compete for a bank.

The host does not address the memory directly. It uses one data-port register. A write to that register stores a byte into the host-side transmit bank. A read from it returns a byte from the host-side receive bank. Each access moves a shared host pointer forward by one. A control register lets software clear the pointer and request a bank exchange for either pair. An exchange waits for a cycle in which the DMA is idle. It then swaps the two banks of the pair and clears the host pointer.

Each bank holds 2^ADDR_W bytes. A full-size buffer uses ADDR_W = 13, which gives 8 KB per bank. The default is a smaller depth.

Top module: `dual_bank_pkt_buf`

## Requirements
- R1: After reset the host pointer is 0, bank 0 of each pair is on the host side, no exchange is pending, and a status read returns 0x00.
- R2: A host write to register 0 (the data port) stores the byte into the host-side transmit bank at the host pointer. The pointer then advances by one and wraps from 2^ADDR_W-1 to 0.
- R3: A host read of register 0 returns the byte of the host-side receive bank at the host pointer, one cycle after the read strobe. The pointer then advances by one.
- R4: Writing register 1 (control) with bit 2 set clears the host pointer to 0.
- R5: Control bit 0 requests a transmit-pair exchange and bit 1 requests a receive-pair exchange. A pending exchange is applied at the first clock edge where neither DMA strobe is high, and that edge also clears the host pointer. While a DMA strobe is high, bank ownership does not change.
- R6: After a transmit exchange, the DMA reads (data one cycle after its read strobe) the bytes the host wrote before the exchange. Later host writes do not change them.
- R7: A DMA write stores into the DMA-side receive bank. After a receive exchange those bytes are readable through the host data port.
- R8: A host write and a DMA access in the same cycle, even at the same address, reach different banks and neither corrupts the other.
- R9: A host read of register 1 returns status one cycle later, taken from the state before that edge: bit 0 = physical transmit bank on the host side, bit 1 = physical receive bank on the host side, bit 2 = transmit exchange pending, bit 3 = receive exchange pending, bits 7:4 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host register write strobe |
| host_re_i | input | 1 | Host register read strobe |
| host_reg_i | input | 1 | Register select: 0 data port, 1 control/status |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, valid one cycle after the read strobe |
| dma_addr_i | input | ADDR_W | DMA byte address within its bank |
| dma_re_i | input | 1 | DMA read strobe (transmit pair) |
| dma_we_i | input | 1 | DMA write strobe (receive pair) |
| dma_wdata_i | input | 8 | DMA write data |
| dma_rdata_o | output | 8 | DMA read data, valid one cycle after the read strobe |

## Verification
The assertions rely on three assumptions about the inputs. The host raises at most one strobe per cycle toward the control register. A host register select applies to whichever host strobe is high in that cycle. The DMA strobes are clean levels, never X, once reset is released. The stimulus drives every input on the falling edge from single-purpose tasks, each of which holds exactly one strobe pattern for one cycle. Exchanges are exercised both with the DMA idle and with a DMA read held high across several cycles, so the deferral path is covered without violating these assumptions.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  localparam int BYTE_W = 8;

  localparam logic REG_DATA = 1'b0;
  localparam logic REG_CTRL = 1'b1;

  localparam int CTRL_TX_SWAP = 0;
  localparam int CTRL_RX_SWAP = 1;
  localparam int CTRL_PTR_CLR = 2;

  typedef struct packed {
    logic [3:0] zero;
    logic       rx_pend;
    logic       tx_pend;
    logic       rx_sel;
    logic       tx_sel;
  } dbb_status_t;
endpackage

// File: rtl/dbb_ram.sv
module dbb_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/dbb_bank_pair.sv
module dbb_bank_pair #(
  parameter int AW          = 10,
  parameter int DW          = 8,
  parameter bit HOST_WRITES = 1'b1  // 1: host fills, dma drains; 0: reverse
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_sel_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [AW-1:0] dma_addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o
);
  logic [1:0][DW-1:0] bank_q;
  logic               rd_bank_q;
  logic               rd_bank;

  assign rd_bank = HOST_WRITES ? ~host_sel_i : host_sel_i;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic          is_host;
    logic          is_writer;
    logic [AW-1:0] addr;

    assign is_host   = (host_sel_i == 1'(g));
    assign is_writer = HOST_WRITES ? is_host : ~is_host;
    assign addr      = is_host ? host_addr_i : dma_addr_i;

    dbb_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk_i   (clk_i),
      .we_i    (wr_en_i & is_writer),
      .re_i    (rd_en_i & ~is_writer),
      .addr_i  (addr),
      .wdata_i (wr_data_i),
      .rdata_o (bank_q[g])
    );
  end

  // remember which bank produced the pending read word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_bank_q <= 1'b0;
    else if (rd_en_i) rd_bank_q <= rd_bank;
  end

  assign rd_data_o = bank_q[rd_bank_q];
endmodule

// File: rtl/dbb_host_ctrl.sv
module dbb_host_ctrl
  import dbb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              reg_i,
  input  logic [2:0]        ctrl_bits_i,
  input  logic              dma_busy_i,
  output logic [AW-1:0]     ptr_o,
  output logic              tx_sel_o,
  output logic              rx_sel_o,
  output logic              tx_pend_o,
  output logic              rx_pend_o,
  output logic              tx_we_o,
  output logic              rx_re_o,
  output logic              stat_sel_o,
  output logic [BYTE_W-1:0] stat_o
);
  logic          data_wr, data_rd, ctrl_wr, stat_rd, do_swap;
  logic [AW-1:0] ptr_q;
  logic          tx_sel_q, rx_sel_q, tx_pend_q, rx_pend_q, stat_sel_q;
  dbb_status_t   stat_q, stat_now;

  assign data_wr = we_i & (reg_i == REG_DATA);
  assign data_rd = re_i & (reg_i == REG_DATA);
  assign ctrl_wr = we_i & (reg_i == REG_CTRL);
  assign stat_rd = re_i & (reg_i == REG_CTRL);
  assign do_swap = (tx_pend_q | rx_pend_q) & ~dma_busy_i;

  always_comb begin
    stat_now         = '0;
    stat_now.tx_sel  = tx_sel_q;
    stat_now.rx_sel  = rx_sel_q;
    stat_now.tx_pend = tx_pend_q;
    stat_now.rx_pend = rx_pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      tx_sel_q   <= 1'b0;
      rx_sel_q   <= 1'b0;
      tx_pend_q  <= 1'b0;
      rx_pend_q  <= 1'b0;
      stat_sel_q <= 1'b0;
      stat_q     <= '0;
    end else begin
      // exchange or explicit clear wins over the auto-increment
      if (do_swap || (ctrl_wr && ctrl_bits_i[CTRL_PTR_CLR])) ptr_q <= '0;
      else if (data_wr || data_rd)                            ptr_q <= ptr_q + 1'b1;

      if (do_swap) begin
        tx_sel_q <= tx_sel_q ^ tx_pend_q;
        rx_sel_q <= rx_sel_q ^ rx_pend_q;
      end
      tx_pend_q <= (tx_pend_q & ~do_swap) | (ctrl_wr & ctrl_bits_i[CTRL_TX_SWAP]);
      rx_pend_q <= (rx_pend_q & ~do_swap) | (ctrl_wr & ctrl_bits_i[CTRL_RX_SWAP]);

      if (re_i)    stat_sel_q <= stat_rd;
      if (stat_rd) stat_q     <= stat_now;
    end
  end

  assign ptr_o      = ptr_q;
  assign tx_sel_o   = tx_sel_q;
  assign rx_sel_o   = rx_sel_q;
  assign tx_pend_o  = tx_pend_q;
  assign rx_pend_o  = rx_pend_q;
  assign tx_we_o    = data_wr;
  assign rx_re_o    = data_rd;
  assign stat_sel_o = stat_sel_q;
  assign stat_o     = stat_q;
endmodule

// File: rtl/dual_bank_pkt_buf.sv
module dual_bank_pkt_buf
  import dbb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic              host_reg_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  input  logic [ADDR_W-1:0] dma_addr_i,
  input  logic              dma_re_i,
  input  logic              dma_we_i,
  input  logic [BYTE_W-1:0] dma_wdata_i,
  output logic [BYTE_W-1:0] dma_rdata_o
);
  logic [ADDR_W-1:0] host_ptr;
  logic              tx_sel, rx_sel, tx_pend, rx_pend;
  logic              tx_we, rx_re, stat_sel, dma_busy;
  logic [BYTE_W-1:0] stat_byte, rx_host_rdata;

  assign dma_busy = dma_re_i | dma_we_i;

  dbb_host_ctrl #(.AW(ADDR_W)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (host_we_i),
    .re_i        (host_re_i),
    .reg_i       (host_reg_i),
    .ctrl_bits_i (host_wdata_i[2:0]),
    .dma_busy_i  (dma_busy),
    .ptr_o       (host_ptr),
    .tx_sel_o    (tx_sel),
    .rx_sel_o    (rx_sel),
    .tx_pend_o   (tx_pend),
    .rx_pend_o   (rx_pend),
    .tx_we_o     (tx_we),
    .rx_re_o     (rx_re),
    .stat_sel_o  (stat_sel),
    .stat_o      (stat_byte)
  );

  dbb_bank_pair #(.AW(ADDR_W), .DW(BYTE_W), .HOST_WRITES(1'b1)) u_tx_pair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_sel_i  (tx_sel),
    .host_addr_i (host_ptr),
    .dma_addr_i  (dma_addr_i),
    .wr_en_i     (tx_we),
    .wr_data_i   (host_wdata_i),
    .rd_en_i     (dma_re_i),
    .rd_data_o   (dma_rdata_o)
  );

  dbb_bank_pair #(.AW(ADDR_W), .DW(BYTE_W), .HOST_WRITES(1'b0)) u_rx_pair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_sel_i  (rx_sel),
    .host_addr_i (host_ptr),
    .dma_addr_i  (dma_addr_i),
    .wr_en_i     (dma_we_i),
    .wr_data_i   (dma_wdata_i),
    .rd_en_i     (rx_re),
    .rd_data_o   (rx_host_rdata)
  );

  assign host_rdata_o = stat_sel ? stat_byte : rx_host_rdata;
endmodule

// File: rtl/dbb_checker.sv
module dbb_checker
  import dbb_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_we_i,
  input logic          host_re_i,
  input logic          host_reg_i,
  input logic          clr_bit_i,
  input logic          dma_busy_i,
  input logic [AW-1:0] ptr_i,
  input logic          tx_sel_i,
  input logic          rx_sel_i,
  input logic          tx_pend_i,
  input logic          rx_pend_i
);
  logic swap_now;
  assign swap_now = (tx_pend_i | rx_pend_i) & ~dma_busy_i;

  assert_hold_while_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_busy_i |=> ($stable(tx_sel_i) && $stable(rx_sel_i)));

  assert_swap_clears_ptr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_now |=> (ptr_i == '0));

  assert_tx_no_spurious_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_pend_i |=> $stable(tx_sel_i));

  assert_rx_no_spurious_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_pend_i |=> $stable(rx_sel_i));

  assert_ptr_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && host_reg_i == REG_CTRL && clr_bit_i) |=> (ptr_i == '0));

  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((host_we_i || host_re_i) && host_reg_i == REG_DATA && !swap_now)
      |=> (ptr_i == AW'($past(ptr_i) + 1'b1)));
endmodule

bind dual_bank_pkt_buf dbb_checker #(.AW(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .host_we_i  (host_we_i),
  .host_re_i  (host_re_i),
  .host_reg_i (host_reg_i),
  .clr_bit_i  (host_wdata_i[2]),
  .dma_busy_i (dma_busy),
  .ptr_i      (host_ptr),
  .tx_sel_i   (tx_sel),
  .rx_sel_i   (rx_sel),
  .tx_pend_i  (tx_pend),
  .rx_pend_i  (rx_pend)
);

// File: tb/dual_bank_pkt_buf_tb.sv
module dual_bank_pkt_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int DEPTH      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_we = 1'b0, host_re = 1'b0, host_reg = 1'b0;
  logic [7:0]        host_wdata = '0;
  logic [7:0]        host_rdata;
  logic [ADDR_W-1:0] dma_addr = '0;
  logic              dma_re = 1'b0, dma_we = 1'b0;
  logic [7:0]        dma_wdata = '0;
  logic [7:0]        dma_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_pkt_buf #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .host_we_i    (host_we),
    .host_re_i    (host_re),
    .host_reg_i   (host_reg),
    .host_wdata_i (host_wdata),
    .host_rdata_o (host_rdata),
    .dma_addr_i   (dma_addr),
    .dma_re_i     (dma_re),
    .dma_we_i     (dma_we),
    .dma_wdata_i  (dma_wdata),
    .dma_rdata_o  (dma_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_wr(input logic r, input logic [7:0] d);
    host_we = 1'b1; host_reg = r; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input logic r, output logic [7:0] d);
    host_re = 1'b1; host_reg = r;
    @(negedge clk);
    d = host_rdata;
    host_re = 1'b0;
  endtask

  task automatic dma_rd(input int a, output logic [7:0] d);
    dma_re = 1'b1; dma_addr = ADDR_W'(a);
    @(negedge clk);
    d = dma_rdata;
    dma_re = 1'b0;
  endtask

  task automatic dma_wr(input int a, input logic [7:0] d);
    dma_we = 1'b1; dma_addr = ADDR_W'(a); dma_wdata = d;
    @(negedge clk);
    dma_we = 1'b0;
  endtask

  task automatic request_swap(input logic [7:0] bits);
    host_wr(1'b1, bits);
    idle(1);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    host_rd(1'b1, d);
    check("R1 status after reset", d, 8'h00);
  endtask

  task automatic t_tx_path;
    logic [7:0] d;
    host_wr(1'b0, 8'h11);
    host_wr(1'b0, 8'h22);
    host_wr(1'b0, 8'h33);
    host_wr(1'b1, 8'h04);            // R4 clear pointer
    host_wr(1'b0, 8'h44);
    request_swap(8'h01);
    host_rd(1'b1, d);
    check("R9 status after tx exchange", d, 8'h01);
    dma_rd(0, d); check("R4 R6 dma byte 0", d, 8'h44);
    dma_rd(1, d); check("R2 R6 dma byte 1", d, 8'h22);
    dma_rd(2, d); check("R2 R6 dma byte 2", d, 8'h33);
  endtask

  task automatic t_parallel;
    logic [7:0] d;
    host_we = 1'b1; host_reg = 1'b0; host_wdata = 8'hAA;
    dma_re = 1'b1; dma_addr = '0;
    @(negedge clk);
    d = dma_rdata;
    host_we = 1'b0; dma_re = 1'b0;
    check("R8 dma read during host write", d, 8'h44);
    dma_rd(0, d); check("R6 dma bank untouched by host", d, 8'h44);
  endtask

  task automatic t_rx_path;
    logic [7:0] d;
    dma_wr(0, 8'h5A);
    dma_wr(1, 8'hA5);
    dma_wr(2, 8'h3C);
    request_swap(8'h02);
    host_rd(1'b1, d);
    check("R9 status after rx exchange", d, 8'h03);
    host_rd(1'b0, d); check("R3 R7 host byte 0", d, 8'h5A);
    host_rd(1'b0, d); check("R3 R7 host byte 1", d, 8'hA5);
    host_rd(1'b0, d); check("R3 R7 host byte 2", d, 8'h3C);
  endtask

  task automatic t_blocked_swap;
    logic [7:0] d;
    dma_re = 1'b1; dma_addr = '0;
    host_wr(1'b1, 8'h01);
    idle(2);
    host_rd(1'b1, d);
    check("R5 exchange held while dma busy", d, 8'h07);
    dma_re = 1'b0;
    idle(1);
    host_rd(1'b1, d);
    check("R5 exchange applied when dma idle", d, 8'h02);
    host_rd(1'b0, d); check("R5 pointer cleared by exchange", d, 8'h5A);
    dma_rd(0, d); check("R8 host byte landed in other bank", d, 8'hAA);
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    host_wr(1'b1, 8'h04);
    for (int i = 0; i < DEPTH; i++) host_wr(1'b0, 8'(i) ^ 8'hC3);
    host_wr(1'b0, 8'hEE);
    request_swap(8'h01);
    dma_rd(0, d);         check("R2 pointer wrap to 0", d, 8'hEE);
    dma_rd(DEPTH - 1, d); check("R2 last address", d, 8'(DEPTH - 1) ^ 8'hC3);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_tx_path;
    t_parallel;
    t_rx_path;
    t_blocked_swap;
    t_wrap;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule